// File: doc/BRIEF.md
# Stochastic TDC Code Unfolder

This block turns the snapshot taken by a stochastic time-to-digital converter into a signed ADC output code. Every conversion brings a wide sample vector, where each bit records whether one delayed clock edge landed inside the folded input pulse. It also brings a fold decision bit that gives the polarity of the input. The block counts the set bits in a pipelined adder tree. It removes the offset built into that count, then gives the magnitude back its polarity.

The count always contains a positive bias, because the folded pulse has a guaranteed minimum width. The block estimates this bias in the background. Over each window of conversions it tracks the smallest count seen, and at the close of the window that minimum becomes the new offset. Software or test logic can freeze the estimate, or write the offset directly through a load port.

Top module: `tdc_code_unfold`

## Requirements
- R1: With offset 0 and a positive fold decision, the output magnitude equals the number of set bits in the sample vector (0 to SAMPLE_BITS), limited only by saturation.
- R2: out_valid rises exactly 4 clock cycles after the cycle in which in_valid was sampled high. Conversions leave the block in the order they entered it, one result for each accepted sample.
- R3: When the count is at least the current offset, the output magnitude is count minus offset.
- R4: When the count is below the current offset, the output code is 0 for either polarity.
- R5: in_neg = 1 marks a negative input: the output is the two's-complement negation of the magnitude. in_neg = 0 gives a non-negative code.
- R6: The signed code saturates to the range -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R7: After reset the offset is 0, out_valid is 0 and out_code is 0.
- R8: While adapt_en is high, every WIN_LEN accepted conversions form one window. On the conversion that closes the window, the offset becomes the minimum count of that window. That conversion itself still uses the old offset. Tracking then restarts with an empty window.
- R9: While adapt_en is low, the offset holds its value and conversions are not counted toward the window.
- R10: A pulse on off_load writes off_load_val into the offset on the next cycle. It takes priority over a window update in the same cycle.
- R11: In cycles where no conversion completes, out_code keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample vector and fold bit are valid this cycle |
| in_neg | input | 1 | Fold decision, 1 = negative input |
| in_sample | input | SAMPLE_BITS | Edge-in-pulse snapshot, one bit per delayed edge |
| adapt_en | input | 1 | Enables background offset estimation |
| off_load | input | 1 | Direct offset write strobe |
| off_load_val | input | CNT_W | Offset value for a direct write |
| out_valid | output | 1 | A signed code is presented this cycle |
| out_code | output | OUT_W | Signed output code |

## Verification
The bench builds the block with SAMPLE_BITS = 31, OUT_W = 5 and WIN_LEN = 8. At these values every count from 0 to 31 can be swept under both polarities and several offsets. Both saturation limits (+15 and -16) and the clamp to zero are reached with short runs. The small window lets the bench close several adaptation windows, including one interrupted by a disabled stretch, and compare the learned offsets with a minimum computed in the bench.

// File: rtl/tdc_unfold_pkg.sv
package tdc_unfold_pkg;

    // Sideband carried alongside each conversion through the count pipeline
    typedef struct packed {
        logic vld;
        logic neg;
    } tdc_side_t;

    localparam int DEF_SAMPLE_BITS = 255;
    localparam int DEF_OUT_W       = 8;
    localparam int DEF_WIN_LEN     = 1024;

endpackage

// File: rtl/tdc_popcount_pipe.sv
module tdc_popcount_pipe
    import tdc_unfold_pkg::*;
#(
    parameter int SAMPLE_BITS = DEF_SAMPLE_BITS,
    parameter int CNT_W       = $clog2(SAMPLE_BITS + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_neg,
    input  logic [SAMPLE_BITS-1:0] in_sample,
    output logic                   cnt_valid,
    output logic                   cnt_neg,
    output logic [CNT_W-1:0]       cnt
);

    localparam int NGRP  = 16;
    localparam int NQUAD = 4;
    localparam int GPQ   = NGRP / NQUAD;
    localparam int GRP_W = (SAMPLE_BITS + NGRP - 1) / NGRP;
    localparam int PAD_W = NGRP * GRP_W;

    typedef struct packed {
        logic      [NGRP-1:0][CNT_W-1:0]  grp;
        logic      [NQUAD-1:0][CNT_W-1:0] quad;
        logic      [CNT_W-1:0]            total;
        tdc_side_t [2:0]                  side;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [PAD_W-1:0] pad;
    logic [CNT_W-1:0] grp_cnt [NGRP];

    assign pad = PAD_W'(in_sample);

    // Stage 1 leaf counters, one per group of the padded vector
    for (genvar g = 0; g < NGRP; g++) begin : g_leaf
        always_comb begin
            grp_cnt[g] = '0;
            for (int b = 0; b < GRP_W; b++) begin
                grp_cnt[g] = grp_cnt[g] + CNT_W'(pad[g*GRP_W + b]);
            end
        end
    end

    always_comb begin
        pipe_d = pipe_q;
        for (int g = 0; g < NGRP; g++) begin
            pipe_d.grp[g] = grp_cnt[g];
        end
        for (int q = 0; q < NQUAD; q++) begin
            pipe_d.quad[q] = '0;
            for (int k = 0; k < GPQ; k++) begin
                pipe_d.quad[q] = pipe_d.quad[q] + pipe_q.grp[q*GPQ + k];
            end
        end
        pipe_d.total = '0;
        for (int q = 0; q < NQUAD; q++) begin
            pipe_d.total = pipe_d.total + pipe_q.quad[q];
        end
        pipe_d.side[0] = '{vld: in_valid, neg: in_neg};
        pipe_d.side[1] = pipe_q.side[0];
        pipe_d.side[2] = pipe_q.side[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign cnt_valid = pipe_q.side[2].vld;
    assign cnt_neg   = pipe_q.side[2].neg;
    assign cnt       = pipe_q.total;

    // R1: a count can never exceed the number of sampled edges
    p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_valid |-> (32'(cnt) <= 32'(SAMPLE_BITS)));

endmodule

// File: rtl/tdc_offset_track.sv
module tdc_offset_track
    import tdc_unfold_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int WIN_LEN = DEF_WIN_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid,
    input  logic [CNT_W-1:0] cnt,
    input  logic             adapt_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] offset
);

    localparam int WC_W = $clog2(WIN_LEN) + 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_LEN - 1);

    typedef struct packed {
        logic [CNT_W-1:0] offset;
        logic [CNT_W-1:0] run_min;
        logic [WC_W-1:0]  wcnt;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [CNT_W-1:0] cand;
    logic             win_end;

    always_comb begin
        trk_d   = trk_q;
        cand    = (cnt < trk_q.run_min) ? cnt : trk_q.run_min;
        win_end = cnt_valid && adapt_en && (trk_q.wcnt == WC_LAST);
        if (cnt_valid && adapt_en) begin
            if (win_end) begin
                trk_d.offset  = cand;
                trk_d.run_min = '1;
                trk_d.wcnt    = '0;
            end else begin
                trk_d.run_min = cand;
                trk_d.wcnt    = trk_q.wcnt + 1'b1;
            end
        end
        if (load) begin
            trk_d.offset = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.offset  <= '0;
            trk_q.run_min <= '1;
            trk_q.wcnt    <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign offset = trk_q.offset;

    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!adapt_en && !load) |=> $stable(offset));

    p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (offset == $past(load_val)));

    p_window_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && adapt_en && !load && (trk_q.wcnt == WC_LAST)) |=> (offset <= $past(cnt)));

endmodule

// File: rtl/tdc_unfold.sv
module tdc_unfold #(
    parameter int CNT_W = 8,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_valid,
    input  logic             cnt_neg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] offset,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code
);

    localparam int EXT_W = ((CNT_W > OUT_W) ? CNT_W : OUT_W) + 1;
    localparam logic [EXT_W-1:0] LIM_POS = EXT_W'((1 << (OUT_W - 1)) - 1);
    localparam logic [EXT_W-1:0] LIM_NEG = LIM_POS + 1'b1;

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] code;
    } res_t;

    res_t res_d, res_q;
    logic [EXT_W-1:0] mag;

    always_comb begin
        res_d     = res_q;
        res_d.vld = cnt_valid;
        mag = (cnt >= offset) ? EXT_W'(cnt - offset) : '0;
        if (cnt_valid) begin
            if (!cnt_neg) begin
                res_d.code = (mag > LIM_POS) ? OUT_W'(LIM_POS) : OUT_W'(mag);
            end else begin
                res_d.code = (mag > LIM_NEG) ? OUT_W'(LIM_NEG) : OUT_W'(EXT_W'(0) - mag);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.vld;
    assign out_code  = res_q.code;

    p_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && (cnt < offset)) |=> (out_code == '0));

    p_nonneg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_valid && !cnt_neg) |=> !out_code[OUT_W-1]);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_valid |=> $stable(out_code));

endmodule

// File: rtl/tdc_code_unfold.sv
module tdc_code_unfold
    import tdc_unfold_pkg::*;
#(
    parameter int SAMPLE_BITS = DEF_SAMPLE_BITS,
    parameter int OUT_W       = DEF_OUT_W,
    parameter int WIN_LEN     = DEF_WIN_LEN,
    localparam int CNT_W      = $clog2(SAMPLE_BITS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_neg,
    input  logic [SAMPLE_BITS-1:0]  in_sample,
    input  logic                    adapt_en,
    input  logic                    off_load,
    input  logic [CNT_W-1:0]        off_load_val,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_code
);

    localparam int LAT = 4;

    logic             cnt_valid;
    logic             cnt_neg;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] offset;
    logic [OUT_W-1:0] code_raw;

    tdc_popcount_pipe #(
        .SAMPLE_BITS (SAMPLE_BITS),
        .CNT_W       (CNT_W)
    ) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_neg    (in_neg),
        .in_sample (in_sample),
        .cnt_valid (cnt_valid),
        .cnt_neg   (cnt_neg),
        .cnt       (cnt)
    );

    tdc_offset_track #(
        .CNT_W   (CNT_W),
        .WIN_LEN (WIN_LEN)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_valid (cnt_valid),
        .cnt       (cnt),
        .adapt_en  (adapt_en),
        .load      (off_load),
        .load_val  (off_load_val),
        .offset    (offset)
    );

    tdc_unfold #(
        .CNT_W (CNT_W),
        .OUT_W (OUT_W)
    ) u_unfold (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_valid (cnt_valid),
        .cnt_neg   (cnt_neg),
        .cnt       (cnt),
        .offset    (offset),
        .out_valid (out_valid),
        .out_code  (code_raw)
    );

    assign out_code = code_raw;

    // Cycles since reset, saturating, used only to arm the latency check
    logic [2:0] warm_d, warm_q;
    always_comb warm_d = (warm_q == 3'(LAT)) ? warm_q : warm_q + 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= '0;
        else        warm_q <= warm_d;
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n || warm_q != 3'(LAT))
        out_valid == $past(in_valid, 4));

endmodule

// File: tb/tdc_code_unfold_bench.sv
module tdc_code_unfold_bench;

    localparam int NB  = 31;
    localparam int OW  = 5;
    localparam int WL  = 8;
    localparam int CW  = $clog2(NB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_neg = 1'b0;
    logic [NB-1:0] in_sample = '0;
    logic adapt_en = 1'b0;
    logic off_load = 1'b0;
    logic [CW-1:0] off_load_val = '0;
    logic out_valid;
    logic signed [OW-1:0] out_code;

    always #4 clk = ~clk;

    tdc_code_unfold #(.SAMPLE_BITS(NB), .OUT_W(OW), .WIN_LEN(WL)) u_tdc_code_unfold (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_neg(in_neg),
        .in_sample(in_sample), .adapt_en(adapt_en), .off_load(off_load),
        .off_load_val(off_load_val), .out_valid(out_valid), .out_code(out_code)
    );

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    string tag_q[$];
    int last_exp = 0;
    bit finished = 0;

    // Bench model of the offset estimator
    int m_off = 0;
    int m_min = 1000;
    int m_wc  = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int expect_code(int k, bit neg, int off);
        int mag;
        mag = (k >= off) ? k - off : 0;
        if (!neg) return (mag > 15) ? 15 : mag;
        return (mag > 16) ? -16 : -mag;
    endfunction

    function automatic logic [NB-1:0] mkvec(int k, int rot);
        logic [NB-1:0] v;
        v = '0;
        for (int i = 0; i < k; i++) v[(i * 7 + rot) % NB] = 1'b1;
        return v;
    endfunction

    task automatic send(input int k, input bit neg, input string tag);
        @(negedge clk);
        in_valid  = 1'b1;
        in_neg    = neg;
        in_sample = mkvec(k, k * 3 + (neg ? 5 : 0));
        exp_q.push_back(expect_code(k, neg, m_off));
        tag_q.push_back(tag);
        if (adapt_en) begin
            if (k < m_min) m_min = k;
            m_wc++;
            if (m_wc == WL) begin
                m_off = m_min;
                m_min = 1000;
                m_wc  = 0;
            end
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic load_off(input int v);
        @(negedge clk);
        off_load = 1'b1;
        off_load_val = CW'(v);
        @(negedge clk);
        off_load = 1'b0;
        m_off = v;
    endtask

    // Output monitor: compares every completed conversion in order
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected result", int'(out_code), 0);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                last_exp = e;
                check(int'(out_code) == e, t, int'(out_code), e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R7: reset state
        check(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
        check(out_code == '0, "R7 out_code in reset", int'(out_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(out_valid == 1'b0, "R7 out_valid after reset", int'(out_valid), 0);

        // R2: exact latency of one conversion
        begin
            logic [3:0] seen;
            send(5, 1'b0, "R1 R7 count with reset offset");
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                in_valid = 1'b0;
                seen[i] = out_valid;
            end
            check(seen == 4'b1000, "R2 latency pattern", int'(seen), 8);
        end
        idle(6);

        // R1 R5 R6 R7: full count sweep, both polarities, offset 0
        for (int k = 0; k <= NB; k++) send(k, 1'b0, "R1 R6 positive sweep");
        for (int k = 0; k <= NB; k++) send(k, 1'b1, "R5 R6 negative sweep");
        idle(8);

        // R11: code holds while idle
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(int'(out_code) == last_exp, "R11 hold when idle", int'(out_code), last_exp);
        end

        // R10 R3 R4: direct load, then sweep around the offset
        load_off(10);
        idle(2);
        for (int k = 0; k <= NB; k++) begin
            send(k, 1'b0, (k < 10) ? "R4 clamp positive" : "R3 subtract positive");
            send(k, 1'b1, (k < 10) ? "R4 clamp negative" : "R3 subtract negative");
        end
        idle(8);

        // R9: adaptation off, small counts must not move the offset
        for (int i = 0; i < 3 * WL; i++) send(2 + (i % 5), i[0], "R9 frozen offset");
        idle(8);

        // R8: first window with adaptation on, load offset 0 first
        load_off(0);
        adapt_en = 1'b1;
        idle(2);
        begin
            int w1[8] = '{20, 15, 7, 25, 31, 9, 12, 18};
            foreach (w1[i]) send(w1[i], i[0], "R8 window one");
        end
        for (int k = 0; k <= NB; k += 3) send(k, 1'b0, "R8 learned offset applied");
        idle(8);

        // R8 R9: window interrupted by a disabled stretch
        m_min = 1000; m_wc = 0;
        load_off(0);
        adapt_en = 1'b0;
        load_off(0);
        idle(2);
        // realign window: a fresh load does not reset the counter, so finish current one
        adapt_en = 1'b1;
        idle(1);
        begin
            int pend;
            pend = (WL - ((32 / 3 + 1) % WL)) % WL;
            // remainder of window started by the previous sweep
            m_wc = (WL - pend) % WL;
            m_min = 1000;
            for (int i = 0; i < pend; i++) send(30, 1'b0, "R8 close partial window");
        end
        idle(8);
        load_off(0);
        idle(2);
        for (int i = 0; i < 4; i++) send(14 + i, 1'b1, "R8 second window part");
        idle(4);
        adapt_en = 1'b0;
        for (int i = 0; i < 6; i++) send(1, 1'b0, "R9 not counted");
        idle(4);
        adapt_en = 1'b1;
        for (int i = 0; i < 4; i++) send(12 + i, 1'b0, "R8 second window end");
        for (int k = 0; k <= NB; k += 2) send(k, 1'b1, "R8 second offset applied");
        idle(10);

        check(exp_q.size() == 0, "R2 all results delivered", exp_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule